// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O

This block gives a processor 24 general-purpose I/O lines arranged as three 8-bit ports: A, B and C. Port C is split into two 4-bit halves, and each half has its own direction. The upper half belongs with port A and the lower half with port B. A control register sets the direction of port A, port B and each half of port C. Only plain input/output operation is provided; there are no strobed or handshaking transfers.

The processor side has an 8-bit data bus with separate input, output and output-enable signals, so a tristate pad can be placed at the chip edge. It also has an active-low chip select, active-low read and write strobes, and a two-bit address. A port set as an output drives the value last written to it. A port set as an input returns the level of its pins, captured on the previous clock. A control write with bit 7 clear does not change directions: it sets or clears one bit of the port C output latch.

Every strobe is sampled on the rising clock edge. A write takes effect once for each assertion of the write strobe. Read data appears on the bus one clock after the read strobe is seen.

Top module: `pio3_port`

## Requirements
- R1: When `rst` is high at a clock edge, all output enables go low, all output latches clear to 0, and a later read of address 3 returns 0x9B.
- R2: A write is taken on the first clock edge that sees `cs_n`=0 and `wr_n`=0. Address 0 loads the port A latch, 1 loads the port B latch, 2 loads the port C latch, and 3 loads the control register.
- R3: A read of address 0, 1 or 2 returns, for each port or half of port C, the output latch if it is an output, or the pins as sampled one edge earlier if it is an input. A read of address 3 returns {1, 0, 0, A_in, CU_in, 0, B_in, CL_in}, with bit 7 on the left.
- R4: A control write with bit 7 = 1 and bits 6, 5 and 2 all 0 is a mode word. In a mode word, bit 4 sets port A to input, bit 3 the upper half of port C (bits 7..4), bit 1 port B, and bit 0 the lower half of port C (bits 3..0); 1 means input and 0 means output. An output's enables are all 1 and an input's are all 0. A mode word also clears all three output latches to 0.
- R5: A control write with bit 7 = 1 and any of bits 6, 5 or 2 set changes neither the directions nor the latches.
- R6: A control write with bit 7 = 0 sets port C latch bit number data[3:1] to data[0]. It leaves the other latch bits and all directions unchanged.
- R7: While `cs_n` is high, `rd_n` and `wr_n` have no effect, and `dbus_oe` is low on the following clock.
- R8: `dbus_oe` is high on the clock after an edge that saw `cs_n`=0, `rd_n`=0 and `wr_n`=1, and it is low otherwise.
- R9: Holding the write strobe low across several edges performs only one write, using the data present on its first edge.
- R10: The two halves of port C keep separate directions, so a port C read can mix pin values in one half with latch values in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| dbus_i | input | 8 | Write data from processor |
| dbus_o | output | 8 | Read data to processor |
| dbus_oe | output | 1 | Drive enable for the processor data pad |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A pad enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B pad enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C pad enables |

## Verification
The assertions assume the processor never drives `rd_n` and `wr_n` low in the same cycle while selected. With both strobes low the block treats the cycle as a write only, and the bus checks would not apply. The stimulus drives every strobe through single-purpose tasks that assert exactly one strobe. Between two accesses the strobe is released for at least one clock, with one exception: the multi-cycle write that exercises single-write-per-strobe behaviour. All inputs change on the falling clock edge, so each rising edge samples settled values.

// File: rtl/pio3_pkg.sv
package pio3_pkg;
  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;
  localparam int BIT_SEL_W = $clog2(PORT_W);

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // 1 = input, per group
  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dir_t;

  function automatic logic [PORT_W-1:0] ctrl_readback(dir_t d);
    return {1'b1, 2'b00, d.a_in, d.cu_in, 1'b0, d.b_in, d.cl_in};
  endfunction
endpackage

// File: rtl/pio3_strobe.sv
module pio3_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_pulse,
  output logic rd_act
);
  logic wr_act;
  logic wr_prev;

  assign wr_act   = !cs_n && !wr_n;
  assign rd_act   = !cs_n && !rd_n && wr_n;
  assign wr_pulse = wr_act && !wr_prev;

  always_ff @(posedge clk) begin
    if (rst) wr_prev <= 1'b0;
    else     wr_prev <= wr_act;
  end
endmodule

// File: rtl/pio3_regs.sv
module pio3_regs
  import pio3_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_pulse,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] din,
  output dir_t              dir,
  output logic [PORT_W-1:0] lat_a,
  output logic [PORT_W-1:0] lat_b,
  output logic [PORT_W-1:0] lat_c
);
  logic mode_word;
  logic mode_ok;
  logic [BIT_SEL_W-1:0] bit_sel;

  assign mode_word = din[7];
  assign mode_ok   = (din[6:5] == 2'b00) && !din[2];
  assign bit_sel   = din[BIT_SEL_W:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir   <= '1;
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (wr_pulse) begin
      case (sel_e'(addr))
        SEL_A: lat_a <= din;
        SEL_B: lat_b <= din;
        SEL_C: lat_c <= din;
        default: begin
          if (mode_word) begin
            if (mode_ok) begin
              dir   <= '{a_in: din[4], cu_in: din[3], b_in: din[1], cl_in: din[0]};
              lat_a <= '0;
              lat_b <= '0;
              lat_c <= '0;
            end
          end else begin
            lat_c[bit_sel] <= din[0];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pio3_group.sv
module pio3_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         is_in,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] lat,
  output logic [W-1:0] oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pins;
  end

  assign oe     = {W{!is_in}};
  assign rd_val = is_in ? pin_q : lat;
endmodule

// File: rtl/pio3_port.sv
module pio3_port
  import pio3_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] dbus_i,
  output logic [PORT_W-1:0] dbus_o,
  output logic              dbus_oe,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  logic wr_pulse, rd_act;
  dir_t dir;
  logic [PORT_W-1:0] lat_a, lat_b, lat_c;
  logic [PORT_W-1:0] rv_a, rv_b;
  logic [HALF_W-1:0] rv_cu, rv_cl, oe_cu, oe_cl;
  logic [PORT_W-1:0] rd_mux;

  pio3_strobe u_strobe (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .wr_pulse(wr_pulse), .rd_act(rd_act)
  );

  pio3_regs u_regs (
    .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .addr(addr), .din(dbus_i),
    .dir(dir), .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c)
  );

  pio3_group #(.W(PORT_W)) u_grp_a (
    .clk(clk), .rst(rst), .is_in(dir.a_in), .pins(pa_in), .lat(lat_a),
    .oe(pa_oe), .rd_val(rv_a)
  );
  pio3_group #(.W(PORT_W)) u_grp_b (
    .clk(clk), .rst(rst), .is_in(dir.b_in), .pins(pb_in), .lat(lat_b),
    .oe(pb_oe), .rd_val(rv_b)
  );
  pio3_group #(.W(HALF_W)) u_grp_cu (
    .clk(clk), .rst(rst), .is_in(dir.cu_in), .pins(pc_in[PORT_W-1:HALF_W]),
    .lat(lat_c[PORT_W-1:HALF_W]), .oe(oe_cu), .rd_val(rv_cu)
  );
  pio3_group #(.W(HALF_W)) u_grp_cl (
    .clk(clk), .rst(rst), .is_in(dir.cl_in), .pins(pc_in[HALF_W-1:0]),
    .lat(lat_c[HALF_W-1:0]), .oe(oe_cl), .rd_val(rv_cl)
  );

  assign pa_out = lat_a;
  assign pb_out = lat_b;
  assign pc_out = lat_c;
  assign pc_oe  = {oe_cu, oe_cl};

  always_comb begin
    case (sel_e'(addr))
      SEL_A:   rd_mux = rv_a;
      SEL_B:   rd_mux = rv_b;
      SEL_C:   rd_mux = {rv_cu, rv_cl};
      default: rd_mux = ctrl_readback(dir);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbus_oe <= 1'b0;
      dbus_o  <= '0;
    end else begin
      dbus_oe <= rd_act;
      dbus_o  <= rd_act ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/pio3_checker.sv
module pio3_checker (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] addr,
  input logic [7:0] dbus_i,
  input logic       dbus_oe,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe
);
  logic seen_wr;
  logic new_wr;
  logic ctl_wr;

  always_ff @(posedge clk) begin
    if (rst) seen_wr <= 1'b0;
    else     seen_wr <= !cs_n && !wr_n;
  end

  assign new_wr = !cs_n && !wr_n && !seen_wr;
  assign ctl_wr = new_wr && (addr == 2'd3);

  // R1
  a_r1_reset_inputs: assert property (@(posedge clk)
    $past(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00));

  // R4
  a_r4_mode_clears: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && dbus_i[7] && dbus_i[6:5] == 2'b00 && !dbus_i[2])
      |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  // R5
  a_r5_bad_mode_ignored: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && dbus_i[7] && (dbus_i[6:5] != 2'b00 || dbus_i[2]))
      |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(pc_out)));

  // R6
  a_r6_bitop_keeps_dirs: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !dbus_i[7])
      |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(pa_out)));

  // R7
  a_r7_cs_high_tristate: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !dbus_oe);

  // R8
  a_r8_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && wr_n) |=> dbus_oe);

  // R10
  a_r10_half_uniform: assert property (@(posedge clk) disable iff (rst)
    ((pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) && (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF)));
endmodule

bind pio3_port pio3_checker u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
  .dbus_i(dbus_i), .dbus_oe(dbus_oe), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/tb_pio3_port.sv
`timescale 1ns/1ps
module tb_pio3_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] dbus_i = 8'h00;
  logic [7:0] dbus_o;
  logic dbus_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int failures = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pio3_port dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .dbus_i(dbus_i), .dbus_o(dbus_o), .dbus_oe(dbus_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // behavioural reference
  bit m_ain, m_cuin, m_bin, m_clin, m_prev, m_oe;
  logic [7:0] m_la, m_lb, m_lc, m_qa, m_qb, m_qc, m_do;

  always @(posedge clk) begin
    logic [7:0] rdata;
    bit wact, ract;
    if (rst) begin
      m_ain = 1; m_cuin = 1; m_bin = 1; m_clin = 1; m_prev = 0; m_oe = 0;
      m_la = 0; m_lb = 0; m_lc = 0; m_qa = 0; m_qb = 0; m_qc = 0; m_do = 0;
    end else begin
      ract = !cs_n && !rd_n && wr_n;
      wact = !cs_n && !wr_n;
      case (addr)
        2'd0: rdata = m_ain ? m_qa : m_la;
        2'd1: rdata = m_bin ? m_qb : m_lb;
        2'd2: rdata = {m_cuin ? m_qc[7:4] : m_lc[7:4], m_clin ? m_qc[3:0] : m_lc[3:0]};
        default: rdata = 8'h80 | (8'(m_ain) << 4) | (8'(m_cuin) << 3) | (8'(m_bin) << 1) | 8'(m_clin);
      endcase
      m_oe = ract;
      m_do = ract ? rdata : 8'h00;
      if (wact && !m_prev) begin
        case (addr)
          2'd0: m_la = dbus_i;
          2'd1: m_lb = dbus_i;
          2'd2: m_lc = dbus_i;
          default:
            if (dbus_i[7]) begin
              if (dbus_i[6:5] == 2'b00 && !dbus_i[2]) begin
                m_ain = dbus_i[4]; m_cuin = dbus_i[3]; m_bin = dbus_i[1]; m_clin = dbus_i[0];
                m_la = 0; m_lb = 0; m_lc = 0;
              end
            end else m_lc[dbus_i[3:1]] = dbus_i[0];
        endcase
      end
      m_prev = wact;
      m_qa = pa_in; m_qb = pb_in; m_qc = pc_in;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R8 dbus_oe vs model", {7'b0, dbus_oe}, {7'b0, m_oe});
      chk("R3 dbus_o vs model", dbus_o, m_do);
      chk("R2 pa_out vs model", pa_out, m_la);
      chk("R2 pb_out vs model", pb_out, m_lb);
      chk("R6 pc_out vs model", pc_out, m_lc);
      chk("R4 pa_oe vs model", pa_oe, m_ain ? 8'h00 : 8'hFF);
      chk("R4 pb_oe vs model", pb_oe, m_bin ? 8'h00 : 8'hFF);
      chk("R10 pc_oe vs model", pc_oe, {m_cuin ? 4'h0 : 4'hF, m_clin ? 4'h0 : 4'hF});
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = a; dbus_i = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = a;
    @(negedge clk);
    chk({tag, " oe"}, {7'b0, dbus_oe}, 8'h01);
    chk(tag, dbus_o, exp);
    cs_n = 1; rd_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; model_on = 1;
    chk("R1 pa_oe after reset", pa_oe, 8'h00);
    chk("R1 pc_out after reset", pc_out, 8'h00);
    rd(2'd3, 8'h9B, "R1 control reset value");
    pa_in = 8'h5A; pc_in = 8'hA5;
    rd(2'd0, 8'h5A, "R3 input port A reads pins");
    wr(2'd3, 8'h80);
    chk("R4 all outputs pa_oe", pa_oe, 8'hFF);
    wr(2'd0, 8'h3C); wr(2'd1, 8'hC3); wr(2'd2, 8'h96);
    rd(2'd0, 8'h3C, "R2 port A latch");
    rd(2'd1, 8'hC3, "R2 port B latch");
    rd(2'd2, 8'h96, "R3 port C latch");
    wr(2'd3, 8'h88);
    chk("R4 mode word clears A", pa_out, 8'h00);
    chk("R10 pc_oe split", pc_oe, 8'h0F);
    rd(2'd3, 8'h88, "R3 control readback");
    wr(2'd3, 8'h03);
    rd(2'd2, 8'hA2, "R10 mixed port C read");
    wr(2'd3, 8'h0F);
    chk("R6 bit op on bit 7", pc_out, 8'h82);
    wr(2'd3, 8'h02);
    chk("R6 bit clear on bit 1", pc_out, 8'h80);
    chk("R6 dirs unchanged", pc_oe, 8'h0F);
    wr(2'd3, 8'hC0);
    chk("R5 bad mode keeps latch", pc_out, 8'h80);
    wr(2'd3, 8'h84);
    rd(2'd3, 8'h88, "R5 bad mode keeps control");
    // chip select high
    @(negedge clk); cs_n = 1; wr_n = 0; addr = 2'd0; dbus_i = 8'hEE;
    @(negedge clk); wr_n = 1; rd_n = 0;
    @(negedge clk);
    chk("R7 write ignored", pa_out, 8'h00);
    chk("R7 bus tristate", {7'b0, dbus_oe}, 8'h00);
    rd_n = 1;
    // held write strobe
    @(negedge clk); cs_n = 0; wr_n = 0; addr = 2'd0; dbus_i = 8'h11;
    @(negedge clk); dbus_i = 8'h22;
    @(negedge clk); dbus_i = 8'h33;
    @(negedge clk); cs_n = 1; wr_n = 1;
    chk("R9 single write per strobe", pa_out, 8'h11);
    pb_in = 8'h77;
    wr(2'd3, 8'h92);
    rd(2'd1, 8'h77, "R3 input port B reads pins");
    rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 reset clears latch", pa_out, 8'h00);
    rd(2'd3, 8'h9B, "R1 control after reset");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule